// File: doc/BRIEF.md
# Single-Upset Injection Run Controller

This block supervises one fault-injection experiment on a processor whose register file can be written from the side. A host sets the run parameters and pulses `start`: the register address to corrupt, the index of the bit to flip, the cycle of the flip, the nominal program length in cycles, and a timeout factor. The controller holds the processor in reset while it captures these values and works out the timeout limit. It then releases the processor and counts the cycles of the run.

At the chosen cycle it raises a one-cycle injection strobe. The strobe goes out with the target address and a one-hot flip mask to the side port of the storage under test, and the processor is never stalled. The controller then waits for the harness to report program completion together with a flag that says whether the result matched. It grades the run as silent, result error or timeout, and holds the processor in reset again until the host starts the next run.

Top module: `seu_run_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `proc_rst` is high, `inj_we`, `busy` and `outcome_valid` are low.
- R2: `start` is accepted only when the controller is idle (`busy` low). A `start` pulse during a run or in its closing cycle changes neither the run length, the strobe nor the outcome, and it does not begin a new run.
- R3: After an accepted `start`, one cycle of parameter loading follows with `proc_rst` still high. `proc_rst` then drops, and that first cycle is run cycle 0. `proc_rst` stays low without a break until the run ends, and the injection adds no cycles: a run that completes in cycle D lasts exactly D+1 cycles.
- R4: `inj_we` is high for exactly one cycle, in run cycle `cfg_cycle` (0 included), provided the run has not ended before that cycle. There is at most one strobe per run.
- R5: While `inj_we` is high, `inj_addr` equals the loaded `cfg_addr` and `inj_mask` is `1 << cfg_bit`, which always has exactly one bit set.
- R6: If `done` arrives in a cycle before `cfg_cycle`, no strobe is issued and the outcome is 2'b00 (silent), whatever `result_ok` says.
- R7: If `done` arrives in the strobe cycle or later, the outcome is 2'b00 when `result_ok` is high and 2'b01 (result error) when it is low.
- R8: The limit is L = floor(`cfg_nominal` * `cfg_factor` / 16), where the factor is unsigned with 4 fraction bits (18 gives 1.125, 80 gives 5.0). If no `done` has arrived by the end of run cycle L, the outcome is 2'b10 (timeout) and the run lasts L+1 cycles.
- R9: A `done` that arrives in run cycle L is graded by R6/R7 and is not counted as a timeout.
- R10: `outcome_valid` and `proc_rst` both rise in the cycle after the run ends. `outcome` and `outcome_valid` then hold until the next `start` is accepted, which clears `outcome_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Host pulse that begins one run |
| cfg_addr | input | ADDR_W (7) | Register address to corrupt |
| cfg_bit | input | BIT_W (5) | Index of the bit to flip |
| cfg_cycle | input | CYC_W (16) | Run cycle of the injection |
| cfg_nominal | input | CYC_W (16) | Nominal program length in cycles |
| cfg_factor | input | FACT_W (8) | Timeout factor, 4 fraction bits |
| done | input | 1 | Harness: program finished this cycle |
| result_ok | input | 1 | Harness: result matched, read together with `done` |
| proc_rst | output | 1 | Reset to the processor under test |
| inj_we | output | 1 | One-cycle injection write strobe |
| inj_addr | output | ADDR_W (7) | Injection target address |
| inj_mask | output | DATA_W (32) | One-hot flip mask |
| busy | output | 1 | High from an accepted start until the controller is idle again |
| outcome_valid | output | 1 | Outcome code is valid |
| outcome | output | 2 | 00 silent, 01 result error, 10 timeout |

## Verification
The assertions assume that `start` is a single-cycle pulse and that the host keeps the configuration steady from that pulse until the run ends. They also assume that `done` and `result_ok` mean something only while `proc_rst` is low. The stimulus sets every configuration field before it raises `start` and does not touch them again until the outcome is read. It drives `done` for exactly one run cycle and clears it as soon as the processor goes back into reset. The injection cycle is kept below the nominal length, and the factors chosen give limits at or above the nominal length. This matches the campaign rule that a flip must land inside the nominal execution window.

// File: rtl/seu_run_pkg.sv
package seu_run_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOAD    = 3'd1,
    ST_RUN     = 3'd2,
    ST_INJECT  = 3'd3,
    ST_MONITOR = 3'd4,
    ST_DONE    = 3'd5
  } run_state_t;

  typedef enum logic [1:0] {
    OUT_SILENT  = 2'b00,
    OUT_RESERR  = 2'b01,
    OUT_TIMEOUT = 2'b10
  } outcome_t;

endpackage

// File: rtl/seu_param_latch.sv
module seu_param_latch #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int BIT_W  = 5,
  parameter int CYC_W  = 16,
  parameter int FACT_W = 8,
  parameter int FRAC_W = 4,
  parameter int LIM_W  = CYC_W + FACT_W - FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BIT_W-1:0]  cfg_bit,
  input  logic [CYC_W-1:0]  cfg_cycle,
  input  logic [CYC_W-1:0]  cfg_nominal,
  input  logic [FACT_W-1:0] cfg_factor,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [CYC_W-1:0]  cycle_q,
  output logic [LIM_W-1:0]  limit_q
);

  localparam int PROD_W = CYC_W + FACT_W;

  logic [CYC_W-1:0]  nominal_q;
  logic [FACT_W-1:0] factor_q;
  logic [PROD_W-1:0] product;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      cycle_q   <= '0;
      nominal_q <= '0;
      factor_q  <= '0;
    end else if (capture) begin
      addr_q    <= cfg_addr;
      cycle_q   <= cfg_cycle;
      nominal_q <= cfg_nominal;
      factor_q  <= cfg_factor;
    end
  end

  // one-hot decode of the bit index, one flop per mask bit
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[gi] <= 1'b0;
      end else if (capture) begin
        mask_q[gi] <= (32'(cfg_bit) == gi);
      end
    end
  end

  // limit registered a cycle after capture; ready by the end of the load cycle
  assign product = PROD_W'(nominal_q) * PROD_W'(factor_q);

  always_ff @(posedge clk) begin
    if (rst) limit_q <= '0;
    else     limit_q <= product[PROD_W-1:FRAC_W];
  end

endmodule

// File: rtl/seu_cycle_counter.sv
module seu_cycle_counter #(
  parameter int CYC_W = 16,
  parameter int LIM_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  input  logic [CYC_W-1:0] inj_cycle,
  input  logic [LIM_W-1:0] limit,
  output logic             inj_next,
  output logic             at_limit
);

  localparam int EXT_W = LIM_W + 1;

  logic [LIM_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_plus;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (advance) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_plus = EXT_W'(cnt_q) + EXT_W'(1);
  assign inj_next = (cnt_plus == EXT_W'(inj_cycle));
  assign at_limit = (cnt_q == limit);

endmodule

// File: rtl/seu_run_fsm.sv
module seu_run_fsm
  import seu_run_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       done,
  input  logic       result_ok,
  input  logic       inj_at_zero,
  input  logic       inj_next,
  input  logic       at_limit,
  output logic       capture,
  output logic       cnt_clear,
  output logic       cnt_adv,
  output logic       proc_rst_q,
  output logic       inj_we_q,
  output logic       busy_q,
  output logic       valid_q,
  output outcome_t   outcome_q
);

  run_state_t state_q;
  logic       running;

  assign running   = (state_q == ST_RUN) || (state_q == ST_INJECT) ||
                     (state_q == ST_MONITOR);
  assign capture   = (state_q == ST_IDLE) && start;
  assign cnt_clear = (state_q == ST_LOAD);
  assign cnt_adv   = running;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      proc_rst_q <= 1'b1;
      inj_we_q   <= 1'b0;
      busy_q     <= 1'b0;
      valid_q    <= 1'b0;
      outcome_q  <= OUT_SILENT;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_LOAD;
            busy_q    <= 1'b1;
            valid_q   <= 1'b0;
            outcome_q <= OUT_SILENT;
          end
        end
        ST_LOAD: begin
          proc_rst_q <= 1'b0;
          if (inj_at_zero) begin
            state_q  <= ST_INJECT;
            inj_we_q <= 1'b1;
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN, ST_INJECT, ST_MONITOR: begin
          inj_we_q <= 1'b0;
          if (done) begin
            state_q    <= ST_DONE;
            proc_rst_q <= 1'b1;
            valid_q    <= 1'b1;
            if (state_q == ST_RUN || result_ok) outcome_q <= OUT_SILENT;
            else                                 outcome_q <= OUT_RESERR;
          end else if (at_limit) begin
            state_q    <= ST_DONE;
            proc_rst_q <= 1'b1;
            valid_q    <= 1'b1;
            outcome_q  <= OUT_TIMEOUT;
          end else if (state_q == ST_RUN && inj_next) begin
            state_q  <= ST_INJECT;
            inj_we_q <= 1'b1;
          end else if (state_q == ST_INJECT) begin
            state_q <= ST_MONITOR;
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
        end
        default: begin
          state_q    <= ST_IDLE;
          proc_rst_q <= 1'b1;
          inj_we_q   <= 1'b0;
          busy_q     <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/seu_run_ctrl.sv
module seu_run_ctrl
  import seu_run_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int BIT_W  = $clog2(DATA_W),
  parameter int CYC_W  = 16,
  parameter int FACT_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BIT_W-1:0]  cfg_bit,
  input  logic [CYC_W-1:0]  cfg_cycle,
  input  logic [CYC_W-1:0]  cfg_nominal,
  input  logic [FACT_W-1:0] cfg_factor,
  input  logic              done,
  input  logic              result_ok,
  output logic              proc_rst,
  output logic              inj_we,
  output logic [ADDR_W-1:0] inj_addr,
  output logic [DATA_W-1:0] inj_mask,
  output logic              busy,
  output logic              outcome_valid,
  output logic [1:0]        outcome
);

  localparam int LIM_W = CYC_W + FACT_W - FRAC_W;

  logic             capture, cnt_clear, cnt_adv;
  logic             inj_next, at_limit;
  logic [CYC_W-1:0] cycle_q;
  logic [LIM_W-1:0] limit_q;
  outcome_t         outcome_q;

  seu_param_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W), .CYC_W(CYC_W),
    .FACT_W(FACT_W), .FRAC_W(FRAC_W), .LIM_W(LIM_W)
  ) u_params (
    .clk(clk), .rst(rst), .capture(capture),
    .cfg_addr(cfg_addr), .cfg_bit(cfg_bit), .cfg_cycle(cfg_cycle),
    .cfg_nominal(cfg_nominal), .cfg_factor(cfg_factor),
    .addr_q(inj_addr), .mask_q(inj_mask), .cycle_q(cycle_q), .limit_q(limit_q)
  );

  seu_cycle_counter #(.CYC_W(CYC_W), .LIM_W(LIM_W)) u_counter (
    .clk(clk), .rst(rst), .clear(cnt_clear), .advance(cnt_adv),
    .inj_cycle(cycle_q), .limit(limit_q),
    .inj_next(inj_next), .at_limit(at_limit)
  );

  seu_run_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .done(done), .result_ok(result_ok),
    .inj_at_zero(cycle_q == '0), .inj_next(inj_next), .at_limit(at_limit),
    .capture(capture), .cnt_clear(cnt_clear), .cnt_adv(cnt_adv),
    .proc_rst_q(proc_rst), .inj_we_q(inj_we), .busy_q(busy),
    .valid_q(outcome_valid), .outcome_q(outcome_q)
  );

  assign outcome = outcome_q;

endmodule

// File: rtl/seu_run_ctrl_chk.sv
module seu_run_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              proc_rst,
  input logic              inj_we,
  input logic [DATA_W-1:0] inj_mask,
  input logic              busy,
  input logic              outcome_valid,
  input logic [1:0]        outcome
);

  logic strobed_q;

  always_ff @(posedge clk) begin
    if (rst || proc_rst) strobed_q <= 1'b0;
    else if (inj_we)     strobed_q <= 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (proc_rst && !inj_we && !busy && !outcome_valid));

  a_r2_accept_idle: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !outcome_valid));

  a_r3_release_busy: assert property (@(posedge clk) disable iff (rst)
    !proc_rst |-> busy);

  a_r3_strobe_in_run: assert property (@(posedge clk) disable iff (rst)
    inj_we |-> !proc_rst);

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    inj_we |=> !inj_we);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    inj_we |-> !strobed_q);

  a_r5_onehot_mask: assert property (@(posedge clk) disable iff (rst)
    inj_we |-> ($countones(inj_mask) == 1));

  a_r8_code_legal: assert property (@(posedge clk) disable iff (rst)
    outcome_valid |-> (outcome != 2'b11));

  a_r10_valid_in_reset: assert property (@(posedge clk) disable iff (rst)
    outcome_valid |-> proc_rst);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (outcome_valid && !start) |=> (outcome_valid && $stable(outcome)));

endmodule

bind seu_run_ctrl seu_run_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .proc_rst(proc_rst), .inj_we(inj_we),
  .inj_mask(inj_mask), .busy(busy), .outcome_valid(outcome_valid),
  .outcome(outcome)
);

// File: tb/seu_run_ctrl_tb.sv
module seu_run_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [4:0]  cfg_bit = '0;
  logic [15:0] cfg_cycle = '0;
  logic [15:0] cfg_nominal = '0;
  logic [7:0]  cfg_factor = '0;
  logic        done = 1'b0;
  logic        result_ok = 1'b0;
  logic        proc_rst, inj_we, busy, outcome_valid;
  logic [6:0]  inj_addr;
  logic [31:0] inj_mask;
  logic [1:0]  outcome;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seu_run_ctrl u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_addr(cfg_addr), .cfg_bit(cfg_bit),
    .cfg_cycle(cfg_cycle), .cfg_nominal(cfg_nominal), .cfg_factor(cfg_factor),
    .done(done), .result_ok(result_ok), .proc_rst(proc_rst), .inj_we(inj_we),
    .inj_addr(inj_addr), .inj_mask(inj_mask), .busy(busy),
    .outcome_valid(outcome_valid), .outcome(outcome)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  // R1: reset state
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(proc_rst == 1'b1, "R1", "proc_rst in reset", proc_rst, 1);
    chk(inj_we == 1'b0 && busy == 1'b0, "R1", "strobe/busy in reset",
        {inj_we, busy}, 0);
    chk(outcome_valid == 1'b0, "R1", "outcome_valid in reset", outcome_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(proc_rst == 1'b1 && !busy, "R1", "idle after reset", {proc_rst, busy}, 2);
  endtask

  // one complete run; done_at < 0 means the program never finishes
  task automatic run_case(input string tag, input int addr, input int bitn,
                          input int inj, input int nom, input int fac,
                          input int done_at, input bit res_ok, input int start_at);
    int lim, endk, exp_code, k, strobes, strobe_k;
    bit mask_ok, addr_ok, gap;
    logic [1:0] held;
    lim  = (nom * fac) >> 4;
    endk = (done_at < 0 || done_at > lim) ? lim : done_at;
    if (done_at < 0 || done_at > lim) exp_code = 2;
    else if (done_at < inj)           exp_code = 0;
    else                              exp_code = res_ok ? 0 : 1;

    @(negedge clk);
    cfg_addr = 7'(addr); cfg_bit = 5'(bitn); cfg_cycle = 16'(inj);
    cfg_nominal = 16'(nom); cfg_factor = 8'(fac); result_ok = res_ok;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(outcome_valid == 1'b0, "R10", {tag, " valid cleared by start"}, outcome_valid, 0);
    chk(proc_rst == 1'b1, "R3", {tag, " load cycle keeps reset"}, proc_rst, 1);

    k = 0; strobes = 0; strobe_k = -1; mask_ok = 1; addr_ok = 1; gap = 0;
    forever begin
      @(negedge clk);
      if (outcome_valid) break;
      if (proc_rst) gap = 1;
      else begin
        if (inj_we) begin
          strobes++;
          strobe_k = k;
          if (inj_mask != (32'h1 << bitn)) mask_ok = 0;
          if (inj_addr != 7'(addr)) addr_ok = 0;
        end
        done  = (k == done_at);
        start = (k == start_at);
        k++;
      end
      if (k > 5000) break;
    end
    done = 1'b0;
    start = 1'b0;

    chk(!gap, "R3", {tag, " reset stays low during run"}, gap, 0);
    chk(k == endk + 1, "R3", {tag, " run length"}, k, endk + 1);
    chk(strobes == ((inj <= endk) ? 1 : 0), "R4", {tag, " strobe count"},
        strobes, (inj <= endk) ? 1 : 0);
    if (inj <= endk) begin
      chk(strobe_k == inj, "R4", {tag, " strobe cycle"}, strobe_k, inj);
      chk(mask_ok, "R5", {tag, " flip mask"}, mask_ok, 1);
      chk(addr_ok, "R5", {tag, " target address"}, addr_ok, 1);
    end
    chk(outcome == 2'(exp_code), tag, "outcome code", outcome, exp_code);
    chk(proc_rst == 1'b1, "R10", {tag, " reset back on at outcome"}, proc_rst, 1);

    held = outcome;
    repeat (3) @(negedge clk);
    chk(outcome_valid && outcome == held && proc_rst, "R10",
        {tag, " outcome held, no new run"}, {outcome_valid, outcome, proc_rst},
        {1'b1, held, 1'b1});
  endtask

  initial begin
    t_reset();
    // silent fault: limit 45, done at nominal
    run_case("R7", 5, 3, 10, 40, 18, 40, 1'b1, -1);
    // result error
    run_case("R7", 9, 31, 20, 40, 18, 39, 1'b0, -1);
    // timeout at limit 45, run lasts 46 cycles
    run_case("R8", 1, 0, 7, 40, 18, -1, 1'b1, -1);
    // done exactly in the limit cycle is graded, not timed out
    run_case("R9", 2, 12, 7, 40, 18, 45, 1'b0, -1);
    // finishes before the injection cycle: silent, no strobe
    run_case("R6", 3, 4, 30, 40, 18, 12, 1'b0, -1);
    // injection in cycle 0
    run_case("R4", 127, 17, 0, 20, 18, 20, 1'b0, -1);
    // done in the strobe cycle itself
    run_case("R7", 64, 8, 15, 20, 18, 15, 1'b0, -1);
    // start pulses during a run are ignored
    run_case("R2", 11, 6, 5, 30, 18, 25, 1'b1, 8);
    // timeout factor 5.0: limit 100
    run_case("R8", 0, 1, 3, 20, 80, -1, 1'b0, -1);
    // done after the limit is still a timeout
    run_case("R8", 4, 2, 6, 16, 16, 20, 1'b1, -1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule